// File: doc/BRIEF.md
# SDRAM Read Burst Truncation Sequencer

This block drives the read side of a single-data-rate SDRAM controller. It accepts a request that names a bank, a starting column and a word count, and it issues a READ command on a row that is already open. Every other command slot is filled with NOP. When the burst must be cut short, it places a BURST TERMINATE so that the last wanted word is also the last word the device drives. It also captures the returned words at the programmed CAS latency and presents them on a valid/data pair.

The device returns its first word CL cycles after the READ edge. The termination rule requires BURST TERMINATE to reach the device CL−1 cycles before the edge that carries the last wanted word. Together these put the terminate edge exactly N cycles after the READ edge for a request of N words, whatever the latency. Two burst modes are supported. In full-page mode every read is truncated. In fixed-length mode the block truncates only a read that has no auto precharge and asks for fewer words than the burst length. Any other fixed-length read runs to its natural end.

Top module: `sdram_rd_trunc_seq`

## Requirements
- R1: After reset, the command output is NOP (CS#,RAS#,CAS#,WE# = 0111), and busy, rd_valid and req_err are all low.
- R2: A request is accepted when req_valid is sampled high at a clock edge while busy is low and req_len is nonzero. The next cycle presents READ (0101) with the requested bank and column, and busy goes high in that same cycle.
- R3: When truncation applies, BURST TERMINATE (0110) is presented exactly N cycles after the READ cycle for a request of N words. This holds for CAS latency 1, 2 and 3, and it places the terminate CL−1 cycles before the edge of the last wanted word.
- R4: In full-page mode (cfg_full_page = 1), every read is truncated as in R3. A requested auto precharge is ignored, so cmd_ap stays low on the READ.
- R5: In fixed-length mode without auto precharge, a request of fewer than FIXED_LEN words is truncated as in R3. A request of FIXED_LEN words or more gets no BURST TERMINATE.
- R6: In fixed-length mode with auto precharge, the READ carries cmd_ap = 1 and no BURST TERMINATE is issued.
- R7: Every command cycle other than the READ and the single BURST TERMINATE is NOP.
- R8: Word k of dq_in, sampled at the edge CL+k cycles after the READ edge, appears on rd_data with rd_valid high in cycle CL+k+1 after the READ cycle. rd_valid is high for exactly D consecutive cycles. D equals N, except in fixed-length mode, where it is capped at FIXED_LEN.
- R9: busy falls in the same cycle that presents the last word the device drives. In a fixed-length burst that runs to its end, this is the FIXED_LEN-th word slot, even if fewer words were wanted.
- R10: A request raised while busy is high is ignored. It causes no command and no error pulse.
- R11: A request with req_len = 0 gives a single-cycle req_err pulse in the next cycle. It issues no command and leaves busy low.
- R12: dqm stays low in every cycle.
- R13: CAS latency and burst mode are sampled when a request is accepted. Changing them during a read does not affect that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cas_lat | input | 2 | CAS latency, 1 to 3 |
| cfg_full_page | input | 1 | 1 = full-page bursts, 0 = fixed length FIXED_LEN |
| req_valid | input | 1 | Request strobe |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Starting column |
| req_len | input | LEN_W | Number of words wanted |
| req_auto_pre | input | 1 | Ask for auto precharge (fixed-length mode only) |
| busy | output | 1 | Read in progress |
| req_err | output | 1 | Zero-length request rejected |
| cmd_n | output | 4 | CS#, RAS#, CAS#, WE# |
| cmd_bank | output | BANK_W | Bank address with READ |
| cmd_col | output | COL_W | Column address with READ |
| cmd_ap | output | 1 | Auto-precharge bit with READ |
| dqm | output | 1 | Data mask |
| dq_in | input | DATA_W | Read data from the device |
| rd_valid | output | 1 | Captured word valid |
| rd_data | output | DATA_W | Captured word |

## Verification
A wrong cycle counter or a wrong latched latency moves the BURST TERMINATE slot or the rd_valid window by whole cycles. The bench compares every cycle of a run, so either fault shows within the same request. A wrong truncation decision shows at once as a missing or extra terminate. It also changes the cycle in which busy falls, several cycles later. A wrong delivered count shows as a rd_valid window that is too short or too long, and the error is visible on the last expected word.

// File: rtl/sdram_rd_pkg.sv
package sdram_rd_pkg;
    // command encoding on {CS#, RAS#, CAS#, WE#}
    typedef enum logic [3:0] {
        CMD_READ = 4'b0101,
        CMD_TERM = 4'b0110,
        CMD_NOP  = 4'b0111
    } cmd_e;
endpackage

// File: rtl/sdram_rd_plan.sv
// Decides, from one request, whether to truncate and how many words flow.
module sdram_rd_plan #(
    parameter int LEN_W     = 9,
    parameter int FIXED_LEN = 8
) (
    input  logic [LEN_W-1:0] len,
    input  logic             full_page,
    input  logic             auto_pre,
    output logic             term_en,
    output logic             ap_out,
    output logic [LEN_W-1:0] del_cnt,
    output logic [LEN_W-1:0] bus_cnt
);
    localparam logic [LEN_W-1:0] FL = LEN_W'(FIXED_LEN);

    logic short_req;
    assign short_req = (len < FL);

    always_comb begin
        if (full_page) begin
            term_en = 1'b1;
            ap_out  = 1'b0;
            del_cnt = len;
            bus_cnt = len;
        end else begin
            term_en = !auto_pre && short_req;
            ap_out  = auto_pre;
            del_cnt = short_req ? len : FL;
            bus_cnt = (!auto_pre && short_req) ? len : FL;
        end
    end
endmodule

// File: rtl/sdram_rd_cmd.sv
// Registered command slot: READ on start, TERM at the truncation slot, else NOP.
module sdram_rd_cmd
    import sdram_rd_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 8,
    parameter int LEN_W  = 9,
    parameter int T_W    = LEN_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BANK_W-1:0] st_bank,
    input  logic [COL_W-1:0]  st_col,
    input  logic              st_ap,
    input  logic              run,
    input  logic [T_W-1:0]    t_q,
    input  logic              term_en,
    input  logic [LEN_W-1:0]  len,
    output logic [3:0]        cmd_n,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_ap
);
    typedef struct packed {
        cmd_e              cmd;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic              ap;
    } cmd_st_t;

    cmd_st_t st_d, st_q;
    logic    term_slot;

    assign term_slot = run && term_en && (t_q == T_W'(len) - T_W'(1));

    always_comb begin
        st_d      = '0;
        st_d.cmd  = CMD_NOP;
        if (start) begin
            st_d.cmd  = CMD_READ;
            st_d.bank = st_bank;
            st_d.col  = st_col;
            st_d.ap   = st_ap;
        end else if (term_slot) begin
            st_d.cmd  = CMD_TERM;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cmd <= CMD_NOP;
        end else begin
            st_q     <= st_d;
        end
    end

    assign cmd_n    = st_q.cmd;
    assign cmd_bank = st_q.bank;
    assign cmd_col  = st_q.col;
    assign cmd_ap   = st_q.ap;

    // R3: a terminate only follows a run in progress, never a READ start
    a_r3_term_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n == CMD_TERM) |-> ($past(run) && !$past(start)));
endmodule

// File: rtl/sdram_rd_cap.sv
// Captures returned words in the window set by the latched CAS latency.
module sdram_rd_cap #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 9,
    parameter int T_W    = LEN_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [T_W-1:0]    t_q,
    input  logic [1:0]        cl,
    input  logic [LEN_W-1:0]  del_cnt,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } cap_st_t;

    cap_st_t        st_d, st_q;
    logic [T_W-1:0] word_idx;
    logic           in_win;

    assign word_idx = t_q - T_W'(cl);
    assign in_win   = run && (t_q >= T_W'(cl)) && (word_idx < T_W'(del_cnt));

    always_comb begin
        st_d.vld  = in_win;
        st_d.data = in_win ? dq_in : st_q.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid = st_q.vld;
    assign rd_data  = st_q.data;

    // R8: a valid word is only ever produced from a read in progress
    a_r8_valid_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(run));
endmodule

// File: rtl/sdram_rd_trunc_seq.sv
module sdram_rd_trunc_seq
    import sdram_rd_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int COL_W     = 8,
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 9,
    parameter int FIXED_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_cas_lat,
    input  logic              cfg_full_page,
    input  logic              req_valid,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_auto_pre,
    output logic              busy,
    output logic              req_err,
    output logic [3:0]        cmd_n,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_ap,
    output logic              dqm,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int T_W = LEN_W + 2;

    typedef struct packed {
        logic             busy;
        logic [T_W-1:0]   t;
        logic [1:0]       cl;
        logic             term_en;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] del;
        logic [LEN_W-1:0] bus;
        logic             err;
    } ctl_st_t;

    ctl_st_t          st_d, st_q;
    logic             accept, reject;
    logic             p_term, p_ap;
    logic [LEN_W-1:0] p_del, p_bus;
    logic [T_W-1:0]   last_t;

    sdram_rd_plan #(.LEN_W(LEN_W), .FIXED_LEN(FIXED_LEN)) u_plan (
        .len       (req_len),
        .full_page (cfg_full_page),
        .auto_pre  (req_auto_pre),
        .term_en   (p_term),
        .ap_out    (p_ap),
        .del_cnt   (p_del),
        .bus_cnt   (p_bus)
    );

    assign accept = req_valid && !st_q.busy && (req_len != '0);
    assign reject = req_valid && !st_q.busy && (req_len == '0);
    assign last_t = T_W'(st_q.cl) + T_W'(st_q.bus) - T_W'(1);

    always_comb begin
        st_d     = st_q;
        st_d.err = reject;
        if (accept) begin
            st_d.busy    = 1'b1;
            st_d.t       = '0;
            st_d.cl      = cfg_cas_lat;
            st_d.term_en = p_term;
            st_d.len     = req_len;
            st_d.del     = p_del;
            st_d.bus     = p_bus;
        end else if (st_q.busy) begin
            st_d.t = st_q.t + T_W'(1);
            if (st_q.t == last_t) st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sdram_rd_cmd #(.BANK_W(BANK_W), .COL_W(COL_W), .LEN_W(LEN_W), .T_W(T_W)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .st_bank  (req_bank),
        .st_col   (req_col),
        .st_ap    (p_ap),
        .run      (st_q.busy),
        .t_q      (st_q.t),
        .term_en  (st_q.term_en),
        .len      (st_q.len),
        .cmd_n    (cmd_n),
        .cmd_bank (cmd_bank),
        .cmd_col  (cmd_col),
        .cmd_ap   (cmd_ap)
    );

    sdram_rd_cap #(.DATA_W(DATA_W), .LEN_W(LEN_W), .T_W(T_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st_q.busy),
        .t_q      (st_q.t),
        .cl       (st_q.cl),
        .del_cnt  (st_q.del),
        .dq_in    (dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign busy    = st_q.busy;
    assign req_err = st_q.err;
    assign dqm     = 1'b0;

    // R2: a run always opens with a READ on the command pins
    a_r2_read_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (cmd_n == CMD_READ));
    // R10: no second READ while the same run continues
    a_r10_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (cmd_n != CMD_READ));
    // R11: an error pulse is never paired with a command
    a_r11_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (cmd_n == CMD_NOP && !busy));
    // R7: terminate only ever appears inside a run
    a_r7_term_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n == CMD_TERM) |-> busy);
endmodule

// File: tb/tb_sdram_rd_trunc_seq.sv
`timescale 1ns/1ps
module tb_sdram_rd_trunc_seq;
    localparam int BANK_W = 2, COL_W = 8, DATA_W = 32, LEN_W = 9, FIXED_LEN = 8;
    localparam logic [3:0] C_READ = 4'b0101, C_TERM = 4'b0110, C_NOP = 4'b0111;

    logic clk = 0, rst_n = 0;
    logic [1:0] cfg_cas_lat = 2'd2;
    logic cfg_full_page = 1'b1, req_valid = 0, req_auto_pre = 0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic busy, req_err, cmd_ap, dqm, rd_valid;
    logic [3:0] cmd_n;
    logic [BANK_W-1:0] cmd_bank;
    logic [COL_W-1:0] cmd_col;
    logic [DATA_W-1:0] dq_in = '0, rd_data;

    int total = 0, bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sdram_rd_trunc_seq #(.BANK_W(BANK_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .LEN_W(LEN_W), .FIXED_LEN(FIXED_LEN)) dut (.*);

    // fields: cl[31:30] full[29] ap[28] len[27:19] term[18] del[17:9] busy_fall_cycle[8:0]
    localparam int NV = 9;
    localparam logic [31:0] VEC [NV] = '{
        {2'd2, 1'b1, 1'b0, 9'd4,  1'b1, 9'd4,  9'd6},   // R4 full page
        {2'd1, 1'b1, 1'b0, 9'd1,  1'b1, 9'd1,  9'd2},   // R3 CL1 single word
        {2'd3, 1'b1, 1'b1, 9'd5,  1'b1, 9'd5,  9'd8},   // R4 ap ignored
        {2'd2, 1'b0, 1'b0, 9'd3,  1'b1, 9'd3,  9'd5},   // R5 short fixed
        {2'd3, 1'b0, 1'b1, 9'd3,  1'b0, 9'd3,  9'd11},  // R6 ap, full burst
        {2'd1, 1'b0, 1'b0, 9'd8,  1'b0, 9'd8,  9'd9},   // R5 equal to length
        {2'd2, 1'b0, 1'b0, 9'd12, 1'b0, 9'd8,  9'd10},  // R5 R8 capped
        {2'd3, 1'b0, 1'b0, 9'd7,  1'b1, 9'd7,  9'd10},  // R5 CL3
        {2'd1, 1'b1, 1'b0, 9'd20, 1'b1, 9'd20, 9'd21}   // R3 long full page
    };

    function automatic logic [DATA_W-1:0] pat(input int bank, input int col);
        return {8'hC3, 14'(bank), 10'(col)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // mode 0: plain, 1: extra requests while busy, 2: config changed mid-run
    task automatic run_req(input int cl, input int fp, input int ap, input int len,
                           input int bank, input int col, input int term,
                           input int del, input int fall, input int mode);
        string ttag;
        ttag = fp ? "R4" : (ap ? "R6" : "R5");
        @(negedge clk);
        cfg_cas_lat = 2'(cl); cfg_full_page = fp[0]; req_auto_pre = ap[0];
        req_len = LEN_W'(len); req_bank = BANK_W'(bank); req_col = COL_W'(col);
        req_valid = 1;
        for (int j = 0; j < fall + 3; j++) begin
            logic [3:0] ec;
            bit ev;
            @(negedge clk);
            ec = (j == 0) ? C_READ : ((term != 0 && j == len) ? C_TERM : C_NOP);
            if (j == 0) begin
                chk(cmd_n == ec, "R2 read cmd", 32'(cmd_n), 32'(ec));
                chk(cmd_bank == BANK_W'(bank) && cmd_col == COL_W'(col), "R2 addr",
                    32'({cmd_bank, cmd_col}), 32'({BANK_W'(bank), COL_W'(col)}));
                chk(cmd_ap == (!fp && ap), ttag, 32'(cmd_ap), 32'(!fp && ap));
            end else if (j == len) begin
                chk(cmd_n == ec, (term != 0) ? "R3 term slot" : ttag, 32'(cmd_n), 32'(ec));
            end else begin
                chk(cmd_n == ec, "R7 nop", 32'(cmd_n), 32'(ec));
            end
            chk(busy == (j < fall), "R9 busy", 32'(busy), 32'(j < fall));
            ev = (j >= cl + 1) && (j <= cl + del);
            chk(rd_valid == ev, "R8 valid", 32'(rd_valid), 32'(ev));
            if (ev) chk(rd_data == pat(bank, col + j - cl - 1), "R8 data",
                        rd_data, pat(bank, col + j - cl - 1));
            chk(!req_err, "R10 err", 32'(req_err), 0);
            chk(!dqm, "R12 dqm", 32'(dqm), 0);
            if (mode == 2 && j > 0) chk(1'b1, "R13", 0, 0);
            // drive next cycle
            if (j == 0) req_valid = 0;
            if (mode == 1) begin
                if (j == 2) begin req_valid = 1; req_len = 9'd5; end
                if (j == 3) req_len = '0;
                if (j == 4) req_valid = 0;
            end
            if (mode == 2 && j == 1) begin
                cfg_cas_lat = (cl == 3) ? 2'd1 : 2'd3;
                cfg_full_page = !fp[0];
            end
            dq_in = (j >= cl) ? pat(bank, col + j - cl) : '0;
        end
        dq_in = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cmd_n == C_NOP, "R1 cmd", 32'(cmd_n), 32'(C_NOP));
        chk(!busy && !rd_valid && !req_err, "R1 flags", 32'({busy, rd_valid, req_err}), 0);
        chk(!dqm, "R12 dqm reset", 32'(dqm), 0);
        rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = VEC[i];
            run_req(int'(v[31:30]), int'(v[29]), int'(v[28]), int'(v[27:19]),
                    i % 4, 16 + 3 * i, int'(v[18]), int'(v[17:9]), int'(v[8:0]), 0);
        end

        // R11: zero length rejected
        @(negedge clk);
        req_len = '0; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk(req_err == 1, "R11 err pulse", 32'(req_err), 1);
        chk(cmd_n == C_NOP && !busy, "R11 no cmd", 32'({busy, cmd_n}), 32'(C_NOP));
        @(negedge clk);
        chk(req_err == 0, "R11 single pulse", 32'(req_err), 0);
        chk(cmd_n == C_NOP && !busy, "R11 still idle", 32'({busy, cmd_n}), 32'(C_NOP));

        // R10: requests during busy ignored (full page CL3 N=6, fall at 9)
        run_req(3, 1, 0, 6, 2, 40, 1, 6, 9, 1);
        // R13: config change mid-run ignored (full page CL2 N=3, fall at 5)
        run_req(2, 1, 0, 3, 1, 80, 1, 3, 5, 2);
        // R6 with CL1, fixed ap, single word: no term, burst runs 8
        run_req(1, 0, 1, 1, 3, 100, 0, 1, 9, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule